// File: doc/BRIEF.md
# Folded half-band low-pass filter

This block is a fixed 47-tap half-band low-pass FIR filter for one real stream of signed 24-bit samples. It keeps the sample rate: each accepted input sample yields exactly one filtered output sample. A complex stream needs two instances, one for the in-phase rail and one for the quadrature rail.

The coefficient set is symmetric about its centre tap, and every tap at an even distance from the centre is zero, except the centre tap itself. The filter adds each mirrored pair of samples before multiplying. It leaves out the zero taps completely. As a result, only twelve pair products and one centre product are formed for each output.

The sum of products is rounded to nearest, scaled down by 2^18 and saturated to 24 bits, which gives a DC gain very close to one. A clear input empties the filter history and the pipeline. A synchronous reset does the same.

Top module: `hb_fir_top`

## Requirements
- R1: Coefficients are indexed from the centre tap. The centre tap holds 131071. The taps at odd distances 1, 3, 5 and so on up to 23 on each side hold 83009, -26536, 14632, -9187, 5990, -3900, 2478, -1505, 855, -440, 194 and -62, in that order going outward. Every other tap is zero. An impulse of amplitude 262144 followed by zeros therefore produces the 47 coefficients as consecutive outputs.
- R2: Let acc be the full-precision sum of x[n-j]*h[j] for j from 0 to 46. Then outData equals (acc + 131072) arithmetically shifted right by 18 bits, for any input sequence.
- R3: When the scaled result is above 8388607, the output is 8388607. When it is below -8388608, the output is -8388608.
- R4: A sample is accepted at a rising edge where inValid is 1. Its result appears, with outValid at 1 for exactly one cycle, after the fourth rising edge that follows the accepting edge.
- R5: Only samples presented with inValid at 1 enter the filter history. inData in cycles where inValid is 0 has no effect on any later output. Each accepted sample yields exactly one output.
- R6: While outValid is 0, outData keeps its last value.
- R7: At a rising edge with clear at 1, the history and every pipeline stage are zeroed. Results still in flight are discarded and never marked valid. outData reads 0 after that edge. A sample presented together with clear is not accepted.
- R8: Reset has the same effect as clear. After reset, outValid is 0 and outData is 0.
- R9: A constant input x, once it has filled all 47 taps, settles to (x*262127 + 131072) arithmetically shifted right by 18 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous flush of history and pipeline |
| inValid | input | 1 | Input sample qualifier |
| inData | input | 24 | Signed input sample |
| outValid | output | 1 | Output sample qualifier |
| outData | output | 24 | Signed filtered sample |

## Verification
Every filtered result is due after the fourth rising edge that follows the edge accepting its sample. When a sample is driven, the bench records the cycle in which its result becomes due. It compares data and valid on the falling edge of exactly that cycle. In every cycle without a due result, it checks that valid is low and that the data is holding.

A clear or a reset discards the records of results that would fall due after the flushing edge. From the cycle after that edge, the expected held value becomes zero. This makes the checks confirm both the flush timing and the loss of in-flight results.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // accept one sample into the history
    logic flush;     // zero history and pipeline
  } hbStrobe_t;

  // Nonzero coefficients: indices 0..11 are the odd-offset pairs going
  // outward from the centre, any other index is the centre tap.
  function automatic int hbCoef(input int idx);
    case (idx)
      0:       return 83009;
      1:       return -26536;
      2:       return 14632;
      3:       return -9187;
      4:       return 5990;
      5:       return -3900;
      6:       return 2478;
      7:       return -1505;
      8:       return 855;
      9:       return -440;
      10:      return 194;
      11:      return -62;
      default: return 131071;
    endcase
  endfunction

endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int PIPE_DEPTH = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clear,
  input  logic      inValid,
  output hbStrobe_t strobe,
  output logic      outValid
);

  logic [PIPE_DEPTH-1:0] validPipe;

  assign strobe.flush   = rst | clear;
  assign strobe.shiftEn = inValid & ~(rst | clear);

  // One valid bit per register stage of the datapath
  always_ff @(posedge clk) begin
    if (strobe.flush) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[PIPE_DEPTH-2:0], strobe.shiftEn};
    end
  end

  assign outValid = validPipe[PIPE_DEPTH-1];

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int COEF_W   = 18,
  parameter int NUM_TAPS = 47,
  parameter int SHIFT    = 18
) (
  input  logic                     clk,
  input  hbStrobe_t                strobe,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [DATA_W-1:0] outData
);

  localparam int MID       = (NUM_TAPS - 1) / 2;
  localparam int NUM_PAIRS = (NUM_TAPS + 1) / 4;
  localparam int NUM_PROD  = NUM_PAIRS + 1;
  localparam int PRE_W     = DATA_W + 1;
  localparam int PROD_W    = PRE_W + COEF_W;
  localparam int ACC_W     = PROD_W + $clog2(NUM_PROD) + 1;

  localparam logic signed [ACC_W-1:0] ROUND_ADD = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] SAT_MAX   = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] SAT_MIN   = -(ACC_W'(1) <<< (DATA_W - 1));

  logic signed [DATA_W-1:0] taps     [NUM_TAPS];
  logic signed [PRE_W-1:0]  preNext  [NUM_PROD];
  logic signed [PRE_W-1:0]  preReg   [NUM_PROD];
  logic signed [PROD_W-1:0] prodReg  [NUM_PROD];
  logic signed [ACC_W-1:0]  sumNext;
  logic signed [ACC_W-1:0]  accReg;
  logic signed [ACC_W-1:0]  rounded;
  logic signed [DATA_W-1:0] satOut;

  function automatic logic signed [PROD_W-1:0] coefAt(input int idx);
    logic signed [COEF_W-1:0] c;
    c = COEF_W'(hbCoef(idx));
    return PROD_W'(c);
  endfunction

  // Fold mirrored taps; the centre tap has no partner
  for (genvar p = 0; p < NUM_PROD; p++) begin : g_pre
    if (p < NUM_PAIRS) begin : g_fold
      localparam int OFS = 2 * p + 1;
      assign preNext[p] = PRE_W'(taps[MID-OFS]) + PRE_W'(taps[MID+OFS]);
    end else begin : g_centre
      assign preNext[p] = PRE_W'(taps[MID]);
    end
  end

  // Adder tree over the registered products
  always_comb begin
    sumNext = '0;
    for (int p = 0; p < NUM_PROD; p++) begin
      sumNext = sumNext + ACC_W'(prodReg[p]);
    end
  end

  // Round to nearest, scale, saturate
  always_comb begin
    rounded = (accReg + ROUND_ADD) >>> SHIFT;
    if (rounded > SAT_MAX) begin
      satOut = SAT_MAX[DATA_W-1:0];
    end else if (rounded < SAT_MIN) begin
      satOut = SAT_MIN[DATA_W-1:0];
    end else begin
      satOut = rounded[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.flush) begin
      for (int i = 0; i < NUM_TAPS; i++) begin
        taps[i] <= '0;
      end
      for (int p = 0; p < NUM_PROD; p++) begin
        preReg[p]  <= '0;
        prodReg[p] <= '0;
      end
      accReg  <= '0;
      outData <= '0;
    end else begin
      if (strobe.shiftEn) begin
        taps[0] <= inData;
        for (int i = 1; i < NUM_TAPS; i++) begin
          taps[i] <= taps[i-1];
        end
      end
      for (int p = 0; p < NUM_PROD; p++) begin
        preReg[p]  <= preNext[p];
        prodReg[p] <= PROD_W'(preReg[p]) * coefAt(p);
      end
      accReg  <= sumNext;
      outData <= satOut;
    end
  end

endmodule

// File: rtl/hb_fir_top.sv
module hb_fir_top
  import hb_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int COEF_W   = 18,
  parameter int NUM_TAPS = 47,
  parameter int SHIFT    = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData
);

  // History, pre-add, product, sum and output registers
  localparam int PIPE_DEPTH = 5;

  hbStrobe_t strobe;

  hb_ctrl #(
    .PIPE_DEPTH(PIPE_DEPTH)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  hb_datapath #(
    .DATA_W  (DATA_W),
    .COEF_W  (COEF_W),
    .NUM_TAPS(NUM_TAPS),
    .SHIFT   (SHIFT)
  ) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .inData (inData),
    .outData(outData)
  );

endmodule

// File: rtl/hb_fir_chk.sv
module hb_fir_chk #(
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     clear,
  input logic                     inValid,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outData
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 5));  // R4

  AST_CLEAR_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    clear |=> !outValid);  // R7

  AST_CLEAR_ZEROES_DATA: assert property (@(posedge clk) disable iff (rst)
    clear |=> (outData == '0));  // R7

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(clear)) |-> $stable(outData));  // R6

endmodule

bind hb_fir_top hb_fir_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clear   (clear),
  .inValid (inValid),
  .outValid(outValid),
  .outData (outData)
);

// File: tb/tb_hb_fir_top.sv
`timescale 1ns/1ps
module tb_hb_fir_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0;
  logic inValid = 1'b0;
  logic signed [23:0] inData = '0;
  logic outValid;
  logic signed [23:0] outData;

  hb_fir_top dut (
    .clk(clk), .rst(rst), .clear(clear), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    due;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   hist [47];
  int   cyc = 0;
  int   clrCyc = -100;
  int   rstCyc = -100;
  int   lastExp = 0;
  bit   monOn = 1'b0;
  bit   done = 1'b0;
  int   checks = 0;
  int   fails = 0;
  int   rng = 32'h1234_5679;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int benchCoef(input int j);
    int d;
    int k;
    d = j - 23;
    if (d == 0) return 131071;
    if (d < 0) d = -d;
    if ((d % 2) == 0) return 0;
    k = (d + 1) / 2;
    case (k)
      1: return 83009;    2: return -26536;   3: return 14632;
      4: return -9187;    5: return 5990;     6: return -3900;
      7: return 2478;     8: return -1505;    9: return 855;
      10: return -440;    11: return 194;     default: return -62;
    endcase
  endfunction

  function automatic int refOut();
    longint acc;
    longint r;
    acc = 0;
    for (int j = 0; j < 47; j++) acc += longint'(hist[j]) * longint'(benchCoef(j));
    r = (acc + 64'sd131072) >>> 18;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return int'(r);
  endfunction

  function automatic int nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >>> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic int to24(input int v);
    logic signed [23:0] t;
    t = v[23:0];
    return int'(t);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  // Drive one valid sample; its result is due four edges after acceptance
  task automatic send(input int x, input string tag);
    exp_t e;
    @(posedge clk); #2;
    inValid = 1'b1;
    inData  = x[23:0];
    for (int j = 46; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    e.due = cyc + 5;
    e.val = refOut();
    e.tag = tag;
    q.push_back(e);
  endtask

  // Idle cycles carry garbage on the data bus (R5)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      inValid = 1'b0;
      inData  = nextRand();
    end
  endtask

  task automatic flushModel();
    while (q.size() > 0 && q[q.size()-1].due > cyc) void'(q.pop_back());
    for (int j = 0; j < 47; j++) hist[j] = 0;
    clrCyc = cyc;
  endtask

  task automatic doClear();
    @(posedge clk); #2;
    clear   = 1'b1;
    inValid = 1'b1;          // R7: this sample must be ignored
    inData  = 24'sh7FFFFF;
    flushModel();
    @(posedge clk); #2;
    clear   = 1'b0;
    inValid = 1'b0;
  endtask

  task automatic doReset(input int n);
    @(posedge clk); #2;
    rst     = 1'b1;
    inValid = 1'b0;
    flushModel();
    repeat (n) @(posedge clk);
    #2;
    rst    = 1'b0;
    rstCyc = cyc;
  endtask

  // Monitor: away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      exp_t e;
      string holdTag;
      if (cyc == clrCyc + 1) lastExp = 0;
      if (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        chk(outValid === 1'b1, "R4", int'(outValid), 1);
        chk(int'(outData) == e.val, e.tag, int'(outData), e.val);
        lastExp = e.val;
      end else begin
        if (cyc <= rstCyc + 6) holdTag = "R8";
        else if (cyc <= clrCyc + 6) holdTag = "R7";
        else holdTag = "R6";
        chk(outValid === 1'b0, holdTag, int'(outValid), 0);
        chk(int'(outData) == lastExp, holdTag, int'(outData), lastExp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int sat [47];
    for (int j = 0; j < 47; j++) hist[j] = 0;
    repeat (4) @(posedge clk);
    #2;
    rst    = 1'b0;
    rstCyc = cyc;
    clrCyc = cyc - 1;
    monOn  = 1'b1;
    idle(6);

    // R1: impulse response reproduces the coefficients
    send(262144, "R1");
    for (int i = 0; i < 50; i++) send(0, "R1");
    idle(3);
    send(-262144, "R1");
    for (int i = 0; i < 47; i++) send(0, "R1");
    idle(6);

    // R9: DC settling at moderate and extreme levels
    for (int i = 0; i < 60; i++) send(100000, "R9");
    for (int i = 0; i < 60; i++) send(-8388608, "R9");
    for (int i = 0; i < 60; i++) send(8388607, "R9");
    idle(6);

    // R3: sign-matched patterns drive the sum past full scale
    for (int j = 0; j < 47; j++) sat[j] = (benchCoef(j) < 0) ? -8388608 : 8388607;
    for (int j = 0; j < 47; j++) send(sat[j], "R3");
    for (int j = 0; j < 47; j++) send((sat[j] < 0) ? 8388607 : -8388608, "R3");
    idle(6);

    // R2: full-range pseudo-random stream
    for (int i = 0; i < 300; i++) send(to24(nextRand()), "R2");
    idle(6);

    // R5: stream with gaps; data in gaps must not matter
    for (int i = 0; i < 200; i++) begin
      send(to24(nextRand()), "R5");
      if ((nextRand() & 3) == 0) idle(1 + (nextRand() & 3));
    end
    idle(6);

    // R7: clear with results in flight, then fresh impulse
    for (int i = 0; i < 10; i++) send(to24(nextRand()), "R7");
    doClear();
    idle(10);
    send(262144, "R7");
    for (int i = 0; i < 30; i++) send(0, "R7");
    idle(6);

    // R8: reset with results in flight
    for (int i = 0; i < 10; i++) send(to24(nextRand()), "R8");
    doReset(2);
    idle(8);
    send(-262144, "R8");
    for (int i = 0; i < 30; i++) send(0, "R8");
    idle(10);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule